// File: doc/BRIEF.md
# Condition Flag Register and Branch Decision Unit

This unit keeps the five processor status flags: negative (N), zero (Z), overflow (V), carry (C) and extend (X). When `valid_i` is high it loads new values from the ALU result flags. Which flags change depends on the operation class presented on `op_i`. Alongside, it resolves a 4-bit condition selector against the stored flags into a single branch-taken bit. This bit is combinational, so decode can act on it in the same cycle.

X is a second carry that survives moves and compares. A chain of extended add or subtract steps therefore sees the carry or borrow of the previous word on `carry_in_o`, even when data moves are interleaved. In extended steps Z can only be cleared. A multiword result then reads as zero only if every word was zero. The signed conditions combine N, V and Z, so they answer correctly even when the compare subtraction overflowed.

Top module: `cc_unit`

## Requirements
- R1: While `rst_ni` is low and after its release, all five flags read 0.
- R2: Arithmetic class (`op_i`=0) with `valid_i` high loads N, Z, V and C from `alu_*_i` at the next clock edge, and loads X with the value of `alu_c_i`.
- R3: Extended class (`op_i`=1) loads N, V and C from the ALU and loads X with `alu_c_i`. The new Z is the old Z ANDed with `alu_z_i`, so this class never sets Z.
- R4: Move class (`op_i`=2) loads N and Z from the ALU, clears V and C, and leaves X unchanged.
- R5: Compare class (`op_i`=3) loads N, Z, V and C from the ALU and leaves X unchanged.
- R6: With `valid_i` low, no flag changes, whatever the other inputs are.
- R7: `carry_in_o` always equals the stored X flag.
- R8: Condition codes 0 and 1 are always-true and always-false. For every even code 2k, the odd code 2k+1 gives the complement of code 2k.
- R9: Unsigned codes after a compare of A minus B: 2 higher (C=0 and Z=0), 3 lower-or-same, 4 carry clear (A>=B), 5 carry set (A<B), 6 not-equal, 7 equal.
- R10: Flag test codes: 8 V clear, 9 V set, 10 N clear, 11 N set.
- R11: Signed codes after a compare: 12 A>=B (N equals V), 13 A<B, 14 A>B (Z clear and N equals V), 15 A<=B. These hold even when the subtraction overflowed.
- R12: `take_o` follows the current flags and `cond_i` in the same cycle, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Flag update strobe |
| op_i | input | 2 | Operation class: 0 arith, 1 extended, 2 move, 3 compare |
| alu_n_i | input | 1 | ALU result negative |
| alu_z_i | input | 1 | ALU result zero |
| alu_v_i | input | 1 | ALU signed overflow |
| alu_c_i | input | 1 | ALU carry / borrow |
| cond_i | input | 4 | Branch condition selector |
| flag_n_o | output | 1 | Stored N |
| flag_z_o | output | 1 | Stored Z |
| flag_v_o | output | 1 | Stored V |
| flag_c_o | output | 1 | Stored C |
| flag_x_o | output | 1 | Stored X |
| carry_in_o | output | 1 | Carry input for extended arithmetic |
| take_o | output | 1 | Branch taken |

## Verification
The hardest case to reach from the ports is a signed compare whose subtraction overflowed. In that case N alone gives the wrong ordering, and only its combination with V is correct. The bench keeps a table of 8-bit operand pairs that includes several overflowing differences. For each pair it models the subtraction flags, loads them through the compare class, and sweeps all 16 codes. Each result is checked against the true signed and unsigned relation of the two operands. Directed sequences then interleave moves and compares within an extended chain, to show that X survives them and that Z stays cleared.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int unsigned OP_W   = 2;
  localparam int unsigned COND_W = 4;
  localparam int unsigned NCOND  = 1 << COND_W;

  typedef enum logic [OP_W-1:0] {
    OP_ARITH = 2'd0,
    OP_EXT   = 2'd1,
    OP_MOVE  = 2'd2,
    OP_CMP   = 2'd3
  } op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
    logic x;
  } ccr_t;
endpackage

// File: rtl/cc_flag_reg.sv
module cc_flag_reg
  import cc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [OP_W-1:0] op_i,
  input  logic            alu_n_i,
  input  logic            alu_z_i,
  input  logic            alu_v_i,
  input  logic            alu_c_i,
  output ccr_t            ccr_o
);
  ccr_t cur_q, nxt;

  always_comb begin
    nxt = cur_q;
    if (valid_i) begin
      unique case (op_e'(op_i))
        OP_ARITH: nxt = '{n: alu_n_i, z: alu_z_i, v: alu_v_i, c: alu_c_i, x: alu_c_i};
        // zero is sticky-clear across a multiword chain
        OP_EXT:   nxt = '{n: alu_n_i, z: cur_q.z & alu_z_i, v: alu_v_i, c: alu_c_i, x: alu_c_i};
        OP_MOVE:  nxt = '{n: alu_n_i, z: alu_z_i, v: 1'b0, c: 1'b0, x: cur_q.x};
        OP_CMP:   nxt = '{n: alu_n_i, z: alu_z_i, v: alu_v_i, c: alu_c_i, x: cur_q.x};
        default:  nxt = cur_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_q <= '0;
    else         cur_q <= nxt;
  end

  assign ccr_o = cur_q;
endmodule

// File: rtl/cc_cond_eval.sv
module cc_cond_eval
  import cc_pkg::*;
(
  input  ccr_t              ccr_i,
  input  logic [COND_W-1:0] cond_i,
  output logic              take_o
);
  localparam int unsigned NPAIR = NCOND / 2;

  logic [NPAIR-1:0] base;
  logic             sgn_ge;

  assign sgn_ge = ~(ccr_i.n ^ ccr_i.v);

  // even code of each pair; odd code is its complement
  always_comb begin
    base[0] = 1'b1;
    base[1] = ~ccr_i.c & ~ccr_i.z;
    base[2] = ~ccr_i.c;
    base[3] = ~ccr_i.z;
    base[4] = ~ccr_i.v;
    base[5] = ~ccr_i.n;
    base[6] = sgn_ge;
    base[7] = sgn_ge & ~ccr_i.z;
  end

  assign take_o = base[cond_i[COND_W-1:1]] ^ cond_i[0];
endmodule

// File: rtl/cc_unit.sv
module cc_unit
  import cc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic              alu_n_i,
  input  logic              alu_z_i,
  input  logic              alu_v_i,
  input  logic              alu_c_i,
  input  logic [COND_W-1:0] cond_i,
  output logic              flag_n_o,
  output logic              flag_z_o,
  output logic              flag_v_o,
  output logic              flag_c_o,
  output logic              flag_x_o,
  output logic              carry_in_o,
  output logic              take_o
);
  ccr_t ccr;

  cc_flag_reg u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .op_i    (op_i),
    .alu_n_i (alu_n_i),
    .alu_z_i (alu_z_i),
    .alu_v_i (alu_v_i),
    .alu_c_i (alu_c_i),
    .ccr_o   (ccr)
  );

  cc_cond_eval u_eval (
    .ccr_i  (ccr),
    .cond_i (cond_i),
    .take_o (take_o)
  );

  assign flag_n_o   = ccr.n;
  assign flag_z_o   = ccr.z;
  assign flag_v_o   = ccr.v;
  assign flag_c_o   = ccr.c;
  assign flag_x_o   = ccr.x;
  assign carry_in_o = ccr.x;
endmodule

// File: rtl/cc_unit_chk.sv
module cc_unit_chk
  import cc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [OP_W-1:0]   op_i,
  input logic              alu_z_i,
  input logic              alu_c_i,
  input logic [COND_W-1:0] cond_i,
  input logic              flag_n_o,
  input logic              flag_z_o,
  input logic              flag_v_o,
  input logic              flag_c_o,
  input logic              flag_x_o,
  input logic              carry_in_o,
  input logic              take_o
);
  a_r2_arith_x_tracks_c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_ARITH |=> flag_x_o == $past(alu_c_i) && flag_c_o == $past(alu_c_i));

  a_r3_ext_z_never_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_EXT |=> !(flag_z_o && !$past(flag_z_o)));

  a_r4_move_keeps_x: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_MOVE |=> $stable(flag_x_o) && !flag_v_o && !flag_c_o);

  a_r5_cmp_keeps_x: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_CMP |=> $stable(flag_x_o));

  a_r6_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable({flag_n_o, flag_z_o, flag_v_o, flag_c_o, flag_x_o}));

  a_r7_carry_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_in_o == flag_x_o);

  a_r8_always_never: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == 4'd0 |-> take_o) and (cond_i == 4'd1 |-> !take_o));

  a_r11_gt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_i == 4'd14 |-> take_o == (!flag_z_o && (flag_n_o == flag_v_o)));

  a_r9_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_i == 4'd2 |-> take_o == (!flag_c_o && !flag_z_o));
endmodule

bind cc_unit cc_unit_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .op_i       (op_i),
  .alu_z_i    (alu_z_i),
  .alu_c_i    (alu_c_i),
  .cond_i     (cond_i),
  .flag_n_o   (flag_n_o),
  .flag_z_o   (flag_z_o),
  .flag_v_o   (flag_v_o),
  .flag_c_o   (flag_c_o),
  .flag_x_o   (flag_x_o),
  .carry_in_o (carry_in_o),
  .take_o     (take_o)
);

// File: tb/tb_cc_unit.sv
module tb_cc_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [1:0] op_i = '0;
  logic       alu_n_i = 1'b0, alu_z_i = 1'b0, alu_v_i = 1'b0, alu_c_i = 1'b0;
  logic [3:0] cond_i = '0;
  logic       flag_n_o, flag_z_o, flag_v_o, flag_c_o, flag_x_o, carry_in_o, take_o;

  int checks = 0;
  int failures = 0;

  always #2 clk_i = ~clk_i;

  cc_unit dut (.*);

  // operand pairs {a,b}; several overflow in a-b
  localparam logic [15:0] PAIRS [12] = '{
    16'h0503, 16'h0305, 16'h0707, 16'h8001, 16'h7FFF, 16'h0180,
    16'hFF01, 16'h0000, 16'h807F, 16'hFFFE, 16'h40C0, 16'h10F0
  };

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0b exp=%0b", req, act, exp);
    end
  endtask

  task automatic upd(input logic [1:0] op, input logic n, z, v, c);
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op;
    alu_n_i = n; alu_z_i = z; alu_v_i = v; alu_c_i = c;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic chk_flags(input logic [4:0] exp, input string req);
    #1;
    chk(flag_n_o, exp[4], {req, " N"});
    chk(flag_z_o, exp[3], {req, " Z"});
    chk(flag_v_o, exp[2], {req, " V"});
    chk(flag_c_o, exp[1], {req, " C"});
    chk(flag_x_o, exp[0], {req, " X"});
    chk(carry_in_o, exp[0], "R7 carry_in");
  endtask

  function automatic logic expect_take(input logic [7:0] a, b, input int code);
    logic [7:0] d;
    d = a - b;
    case (code)
      0:  return 1'b1;
      1:  return 1'b0;
      2:  return a > b;
      3:  return a <= b;
      4:  return a >= b;
      5:  return a < b;
      6:  return a != b;
      7:  return a == b;
      8:  return !((a[7] != b[7]) && (d[7] != a[7]));
      9:  return (a[7] != b[7]) && (d[7] != a[7]);
      10: return !d[7];
      11: return d[7];
      12: return $signed(a) >= $signed(b);
      13: return $signed(a) < $signed(b);
      14: return $signed(a) > $signed(b);
      default: return $signed(a) <= $signed(b);
    endcase
  endfunction

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 reset
    #3;
    chk_flags(5'b00000, "R1 in reset");
    @(negedge clk_i); rst_ni = 1'b1;
    chk_flags(5'b00000, "R1 after reset");

    // R8 R9 R10 R11 compare sweep
    for (int i = 0; i < 12; i++) begin
      logic [7:0] a, b;
      logic [8:0] d9;
      a = PAIRS[i][15:8]; b = PAIRS[i][7:0];
      d9 = {1'b0, a} - {1'b0, b};
      upd(2'd3, d9[7], d9[7:0] == 8'd0,
          (a[7] != b[7]) && (d9[7] != a[7]), d9[8]);
      for (int k = 0; k < 16; k++) begin
        cond_i = 4'(k);
        #1;
        chk(take_o, expect_take(a, b, k),
            (k < 2) ? "R8 const" : (k < 8) ? "R9 unsigned" :
            (k < 12) ? "R10 flag test" : "R11 signed");
      end
    end

    // R2 arithmetic sets X from carry
    upd(2'd0, 1'b1, 1'b0, 1'b1, 1'b1);
    chk_flags(5'b10111, "R2 arith");
    // R5 compare keeps X
    upd(2'd3, 1'b0, 1'b1, 1'b0, 1'b0);
    chk_flags(5'b01001, "R5 cmp");
    // R4 move clears V,C, keeps X
    upd(2'd0, 1'b0, 1'b0, 1'b1, 1'b1);
    upd(2'd2, 1'b1, 1'b0, 1'b1, 1'b1);
    chk_flags(5'b10001, "R4 move");
    // R6 idle ignores inputs
    @(negedge clk_i);
    op_i = 2'd0; alu_n_i = 1'b0; alu_z_i = 1'b1; alu_v_i = 1'b1; alu_c_i = 1'b0;
    @(negedge clk_i);
    chk_flags(5'b10001, "R6 idle");

    // R3 extended chain: Z sticky-clear
    upd(2'd0, 1'b0, 1'b1, 1'b0, 1'b1);
    upd(2'd1, 1'b0, 1'b1, 1'b0, 1'b0);
    chk_flags(5'b01000, "R3 ext zero kept");
    upd(2'd1, 1'b0, 1'b0, 1'b0, 1'b1);
    chk_flags(5'b00011, "R3 ext nonzero clears");
    upd(2'd2, 1'b0, 1'b1, 1'b0, 1'b0);
    chk_flags(5'b01001, "R4 move mid chain");
    upd(2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    upd(2'd1, 1'b1, 1'b1, 1'b1, 1'b0);
    chk_flags(5'b10100, "R3 ext never sets Z");

    // R12 same-cycle response to cond_i
    cond_i = 4'd11; #1;
    chk(take_o, 1'b1, "R12 comb MI");
    cond_i = 4'd10; #1;
    chk(take_o, 1'b0, "R12 comb PL");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule